// File: doc/BRIEF.md
# Function/Subaddress Command Decoder

This block is the slave side of a dataflow crate bus. On each command strobe it decodes a 5-bit function code and a 4-bit subaddress. It then applies the command to the module's internal resources and answers with read data and two response bits. The resources are:

- a 64-entry word FIFO whose entries carry a tag bit;
- a counter of tagged words;
- two 24-bit message counters, one for good messages and one for bad;
- a station-address register;
- a receiver-enable bit;
- an interrupt-request enable.

The X bit says the command was recognised. The Q bit says it was carried out.

While the receive path reports that a frame is arriving, the block refuses every command. A refused command still answers X=1, but it gives Q=0 and has no effect. The response is registered and appears one clock after the strobe. It is qualified by `rsp_valid`. The block also drives an interrupt request, the receiver enable, the station address and a one-cycle receiver re-initialise pulse.

Top module: `fa_cmd_decoder`

## Requirements
- R1: F0 with subaddress 0 or 1 pops the FIFO head. The data returns on `rsp_rdata[15:0]` and the tag on `rsp_rdata[16]`, with Q=1. If the FIFO is empty, the pop returns Q=0 and `rsp_rdata`=0.
- R2: F16 with subaddress 0 or 1 stores `cmd_wdata[15:0]` in the FIFO, with a tag equal to subaddress bit 0. If the FIFO holds 64 words, the write gives Q=0 and nothing is stored.
- R3: The tagged-word count is handled as follows:
  - F0 A2/A3 reads it on `rsp_rdata[7:0]`.
  - Storing a tagged word raises it by one, and popping a tagged word lowers it by one.
  - F16 A2/A3 loads it from `cmd_wdata[7:0]`.
  - F8 A0 returns Q=1 exactly when the count is nonzero.
- R4: The message counters work as follows:
  - F0 A4/A5 reads the good-message count and F0 A6/A7 reads the bad-message count, on `rsp_rdata[23:0]`.
  - F16 A4 and F16 A6 increment the good and bad counter respectively.
  - F16 A5 and F16 A7 clear the good and bad counter respectively.
  - Each counter wraps from its all-ones value to 0.
- R5: F16 A8 loads the station address from `cmd_wdata[7:0]`. F0 A8 reads it back on `rsp_rdata[7:0]`, and `station_addr` always shows it.
- R6: F1 A0 returns the channel status byte on `rsp_rdata[7:0]`:
  - bit 7 is 1 when no tagged word is counted;
  - bit 6 is 1 when the FIFO is not full;
  - bit 5 is 1 when the FIFO is not empty;
  - bit 4 is `carrier_det`;
  - bits 3:0 are `chan_id`.
- R7: F17 A1 sets the receiver enable from `cmd_wdata[0]`. F24 A0 disables and F26 A0 enables the interrupt request. F1 A1 reads back `rsp_rdata[0]` = receiver enable and `rsp_rdata[1]` = interrupt enable. `lam_req` is high exactly when the interrupt is enabled and the tagged count is nonzero.
- R8: F9 or F11, with any subaddress, resets the module. The reset empties the FIFO and clears the tagged count, both message counters and the station address. It also disables the interrupt, sets the receiver enable, and pulses `rx_init` high for exactly one cycle.
- R9: Every decoded command answers X=1. The response appears one cycle after the strobe with `rsp_valid`=1. Q=1 unless R1, R2, R3 or R10 say otherwise. A write-type command returns `rsp_rdata`=0.
- R10: While `rx_busy`=1, a decoded command answers X=1, Q=0 and `rsp_rdata`=0, and changes no state.
- R11: A function/subaddress pair that is not listed here answers X=0, Q=0 and `rsp_rdata`=0, and has no side effect.
- R12: After the external reset, the block is in the R8 state with `rsp_valid`=0 and `rx_init`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | Command strobe, one cycle per command |
| cmd_func | input | 5 | Function code |
| cmd_sub | input | 4 | Subaddress |
| cmd_wdata | input | 16 | Write data |
| rx_busy | input | 1 | Frame reception in progress |
| carrier_det | input | 1 | Modem carrier present |
| chan_id | input | 4 | Strapped channel number |
| rsp_valid | output | 1 | Response valid, one cycle after the strobe |
| rsp_x | output | 1 | Command recognised |
| rsp_q | output | 1 | Command performed |
| rsp_rdata | output | 24 | Read data |
| lam_req | output | 1 | Interrupt request |
| rx_enable | output | 1 | Receiver enable |
| station_addr | output | 8 | Station address |
| rx_init | output | 1 | Receiver re-initialise pulse |

## Verification
Two situations are hard to reach from the ports.

The wrap of a 24-bit message counter would need about sixteen million increments. The bench therefore runs a second instance with 4-bit counters from the same command stream. Seventeen increments carry that instance across the wrap, while the default instance reads 17 at the same time.

The full-FIFO boundary is reached by 64 alternating tagged and untagged writes. Those writes also bring the tagged count to 32 and turn the status byte to its "full" pattern. A 65th write must be refused, and the pops that follow must return every word and tag in order.

The refusal rule is driven directly through `rx_busy`. This covers the reset command as well: a refused reset must leave the station address intact.

// File: rtl/fa_cmd_pkg.sv
package fa_cmd_pkg;

  localparam logic [4:0] FN_RD      = 5'd0;
  localparam logic [4:0] FN_RD_STAT = 5'd1;
  localparam logic [4:0] FN_TEST    = 5'd8;
  localparam logic [4:0] FN_RST_A   = 5'd9;
  localparam logic [4:0] FN_RST_B   = 5'd11;
  localparam logic [4:0] FN_WR      = 5'd16;
  localparam logic [4:0] FN_WR_CTL  = 5'd17;
  localparam logic [4:0] FN_IRQ_OFF = 5'd24;
  localparam logic [4:0] FN_IRQ_ON  = 5'd26;

  typedef enum logic [4:0] {
    OP_NONE,
    OP_FIFO_RD,
    OP_TAG_RD,
    OP_GOOD_RD,
    OP_BAD_RD,
    OP_ADDR_RD,
    OP_CHAN_RD,
    OP_CTRL_RD,
    OP_IRQ_TEST,
    OP_RESET,
    OP_FIFO_WR,
    OP_TAG_WR,
    OP_GOOD_INC,
    OP_GOOD_CLR,
    OP_BAD_INC,
    OP_BAD_CLR,
    OP_ADDR_WR,
    OP_RXEN_WR,
    OP_IRQ_DIS,
    OP_IRQ_EN
  } op_e;

endpackage

// File: rtl/fa_op_decode.sv
module fa_op_decode
  import fa_cmd_pkg::*;
(
  input  logic [4:0] func,
  input  logic [3:0] sub,
  output op_e        op
);

  always_comb begin
    op = OP_NONE;
    unique case (func)
      FN_RD: begin
        unique case (sub)
          4'd0, 4'd1: op = OP_FIFO_RD;
          4'd2, 4'd3: op = OP_TAG_RD;
          4'd4, 4'd5: op = OP_GOOD_RD;
          4'd6, 4'd7: op = OP_BAD_RD;
          4'd8:       op = OP_ADDR_RD;
          default:    op = OP_NONE;
        endcase
      end
      FN_RD_STAT: begin
        if (sub == 4'd0)      op = OP_CHAN_RD;
        else if (sub == 4'd1) op = OP_CTRL_RD;
      end
      FN_TEST: begin
        if (sub == 4'd0) op = OP_IRQ_TEST;
      end
      FN_RST_A, FN_RST_B: op = OP_RESET;
      FN_WR: begin
        unique case (sub)
          4'd0, 4'd1: op = OP_FIFO_WR;
          4'd2, 4'd3: op = OP_TAG_WR;
          4'd4:       op = OP_GOOD_INC;
          4'd5:       op = OP_GOOD_CLR;
          4'd6:       op = OP_BAD_INC;
          4'd7:       op = OP_BAD_CLR;
          4'd8:       op = OP_ADDR_WR;
          default:    op = OP_NONE;
        endcase
      end
      FN_WR_CTL: begin
        if (sub == 4'd1) op = OP_RXEN_WR;
      end
      FN_IRQ_OFF: begin
        if (sub == 4'd0) op = OP_IRQ_DIS;
      end
      FN_IRQ_ON: begin
        if (sub == 4'd0) op = OP_IRQ_EN;
      end
      default: op = OP_NONE;
    endcase
  end

endmodule

// File: rtl/fa_word_fifo.sv
module fa_word_fifo #(
  parameter int WIDTH = 17,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);

  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]      level;
  logic             push_ok, pop_ok;

  assign empty   = (wr_q == rd_q);
  assign full    = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rd_q[AW-1:0]];
  assign level   = wr_q - rd_q;

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (clr) begin
      wr_d = '0;
      rd_d = '0;
    end else begin
      if (push_ok) wr_d = wr_q + 1'b1;
      if (pop_ok)  rd_d = rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_q[AW-1:0]] <= wdata;
  end

  // R2
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop && !clr |=> full && (level == DEPTH[AW:0]));

  // R1
  fifo_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty && !push && !clr |=> empty);

  // R2
  fifo_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH[AW:0]);

  // R8
  fifo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);

endmodule

// File: rtl/fa_msg_counter.sv
module fa_msg_counter #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [WIDTH-1:0] count
);

  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    cnt_d = count;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_d;
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !clr |=> count == $past(count) + 1'b1);

  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc && !clr |=> $stable(count));

endmodule

// File: rtl/fa_cmd_decoder.sv
module fa_cmd_decoder
  import fa_cmd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 24,
  parameter int FIFO_DEPTH = 64,
  parameter int TAG_W      = 8,
  parameter int ADDR_W     = 8,
  parameter int CHAN_W     = 4,
  parameter int RD_W       = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic [4:0]        cmd_func,
  input  logic [3:0]        cmd_sub,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              rx_busy,
  input  logic              carrier_det,
  input  logic [CHAN_W-1:0] chan_id,
  output logic              rsp_valid,
  output logic              rsp_x,
  output logic              rsp_q,
  output logic [RD_W-1:0]   rsp_rdata,
  output logic              lam_req,
  output logic              rx_enable,
  output logic [ADDR_W-1:0] station_addr,
  output logic              rx_init
);

  localparam int FW     = DATA_W + 1;
  localparam int STAT_W = CHAN_W + 4;
  localparam int NCNT   = 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  op_e op;
  fa_op_decode u_decode (.func(cmd_func), .sub(cmd_sub), .op(op));

  logic decoded, accept, do_reset;
  assign decoded  = cmd_stb && (op != OP_NONE);
  assign accept   = decoded && !rx_busy;
  assign do_reset = accept && (op == OP_RESET);

  // FIFO
  logic          fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [FW-1:0] fifo_rdata;
  logic          push_ok, pop_ok;

  assign fifo_push = accept && (op == OP_FIFO_WR);
  assign fifo_pop  = accept && (op == OP_FIFO_RD);
  assign push_ok   = fifo_push && !fifo_full;
  assign pop_ok    = fifo_pop && !fifo_empty;

  fa_word_fifo #(.WIDTH(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (do_reset),
    .push  (fifo_push),
    .pop   (fifo_pop),
    .wdata ({cmd_sub[0], cmd_wdata}),
    .rdata (fifo_rdata),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  // message counters: index 0 good, index 1 bad
  logic             cnt_inc [NCNT];
  logic             cnt_clr [NCNT];
  logic [CNT_W-1:0] cnt_val [NCNT];

  assign cnt_inc[0] = accept && (op == OP_GOOD_INC);
  assign cnt_clr[0] = (accept && (op == OP_GOOD_CLR)) || do_reset;
  assign cnt_inc[1] = accept && (op == OP_BAD_INC);
  assign cnt_clr[1] = (accept && (op == OP_BAD_CLR)) || do_reset;

  for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
    fa_msg_counter #(.WIDTH(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (cnt_clr[gi]),
      .inc   (cnt_inc[gi]),
      .count (cnt_val[gi])
    );
  end

  // control state
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rxen_q, rxen_d, irq_en_q, irq_en_d;
  logic              tag_inc, tag_dec, tag_any;

  assign tag_inc = push_ok && cmd_sub[0];
  assign tag_dec = pop_ok && fifo_rdata[FW-1];
  assign tag_any = (tag_q != '0);

  always_comb begin
    tag_d    = tag_q;
    addr_d   = addr_q;
    rxen_d   = rxen_q;
    irq_en_d = irq_en_q;
    if (do_reset) begin
      tag_d    = '0;
      addr_d   = '0;
      rxen_d   = 1'b1;
      irq_en_d = 1'b0;
    end else if (accept) begin
      unique case (op)
        OP_TAG_WR:  tag_d    = cmd_wdata[TAG_W-1:0];
        OP_ADDR_WR: addr_d   = cmd_wdata[ADDR_W-1:0];
        OP_RXEN_WR: rxen_d   = cmd_wdata[0];
        OP_IRQ_DIS: irq_en_d = 1'b0;
        OP_IRQ_EN:  irq_en_d = 1'b1;
        default: begin
          if (tag_inc && !tag_dec && (tag_q != '1)) tag_d = tag_q + 1'b1;
          if (tag_dec && !tag_inc && tag_any)       tag_d = tag_q - 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tag_q    <= '0;
      addr_q   <= '0;
      rxen_q   <= 1'b1;
      irq_en_q <= 1'b0;
    end else begin
      tag_q    <= tag_d;
      addr_q   <= addr_d;
      rxen_q   <= rxen_d;
      irq_en_q <= irq_en_d;
    end
  end

  // response
  logic [STAT_W-1:0] chan_status;
  logic              x_d, q_d;
  logic [RD_W-1:0]   rd_d;

  assign chan_status = {!tag_any, !fifo_full, !fifo_empty, carrier_det, chan_id};

  always_comb begin
    x_d  = decoded;
    q_d  = accept;
    rd_d = '0;
    if (accept) begin
      unique case (op)
        OP_FIFO_RD: begin
          q_d = !fifo_empty;
          if (!fifo_empty) rd_d = RD_W'(fifo_rdata);
        end
        OP_FIFO_WR:  q_d  = !fifo_full;
        OP_IRQ_TEST: q_d  = tag_any;
        OP_TAG_RD:   rd_d = RD_W'(tag_q);
        OP_GOOD_RD:  rd_d = RD_W'(cnt_val[0]);
        OP_BAD_RD:   rd_d = RD_W'(cnt_val[1]);
        OP_ADDR_RD:  rd_d = RD_W'(addr_q);
        OP_CHAN_RD:  rd_d = RD_W'(chan_status);
        OP_CTRL_RD:  rd_d = RD_W'({irq_en_q, rxen_q});
        default:     rd_d = '0;
      endcase
    end
  end

  logic init_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_x     <= 1'b0;
      rsp_q     <= 1'b0;
      rsp_rdata <= '0;
      init_q    <= 1'b0;
    end else begin
      rsp_valid <= cmd_stb;
      rsp_x     <= x_d;
      rsp_q     <= q_d;
      rsp_rdata <= rd_d;
      init_q    <= do_reset;
    end
  end

  assign rx_init      = init_q;
  assign lam_req      = irq_en_q && tag_any;
  assign rx_enable    = rxen_q;
  assign station_addr = addr_q;

  // R10
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_stb && rx_busy |=> rsp_valid && !rsp_q && (rsp_rdata == '0));

  // R10
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_stb && rx_busy |=> $stable(station_addr) && $stable(rx_enable));

  // R11
  undecoded_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_stb && (op == OP_NONE) |=> rsp_valid && !rsp_x && !rsp_q && (rsp_rdata == '0));

  // R9
  decoded_x_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    decoded |=> rsp_valid && rsp_x);

  // R8
  reset_effect_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    do_reset |=> rx_init && !lam_req && rx_enable && (station_addr == '0));

  // R8
  init_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_init |=> !rx_init);

endmodule

// File: tb/fa_cmd_decoder_tb.sv
module fa_cmd_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV         = 37;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_stb;
  logic [4:0]  cmd_func;
  logic [3:0]  cmd_sub;
  logic [15:0] cmd_wdata;
  logic        rx_busy;
  logic        carrier_det;
  logic [3:0]  chan_id;

  logic        rsp_valid, rsp_x, rsp_q, lam_req, rx_enable, rx_init;
  logic [23:0] rsp_rdata;
  logic [7:0]  station_addr;

  logic        n_valid, n_x, n_q, n_lam, n_rxen, n_init;
  logic [23:0] n_rdata;
  logic [7:0]  n_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  fa_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_func(cmd_func),
    .cmd_sub(cmd_sub), .cmd_wdata(cmd_wdata), .rx_busy(rx_busy),
    .carrier_det(carrier_det), .chan_id(chan_id),
    .rsp_valid(rsp_valid), .rsp_x(rsp_x), .rsp_q(rsp_q), .rsp_rdata(rsp_rdata),
    .lam_req(lam_req), .rx_enable(rx_enable), .station_addr(station_addr),
    .rx_init(rx_init)
  );

  // narrow counters so that the wrap of R4 is reachable
  fa_cmd_decoder #(.CNT_W(4)) u_dut_narrow (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_func(cmd_func),
    .cmd_sub(cmd_sub), .cmd_wdata(cmd_wdata), .rx_busy(rx_busy),
    .carrier_det(carrier_det), .chan_id(chan_id),
    .rsp_valid(n_valid), .rsp_x(n_x), .rsp_q(n_q), .rsp_rdata(n_rdata),
    .lam_req(n_lam), .rx_enable(n_rxen), .station_addr(n_addr),
    .rx_init(n_init)
  );

  typedef struct packed {
    logic [4:0]  f;
    logic [3:0]  a;
    logic        busy;
    logic [15:0] wd;
    logic        ex;
    logic        eq;
    logic [23:0] erd;
    logic [7:0]  rq;
  } vec_t;

  // carrier_det = 1, chan_id = 4'hA during the table
  localparam vec_t VECS [NV] = '{
    '{5'd1,  4'd0,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h0000DA, 8'd6},  // R6 idle status
    '{5'd0,  4'd0,  1'b0, 16'h0000, 1'b1, 1'b0, 24'h000000, 8'd1},  // R1 pop empty
    '{5'd16, 4'd0,  1'b0, 16'h1234, 1'b1, 1'b1, 24'h000000, 8'd2},  // R2 untagged write
    '{5'd16, 4'd1,  1'b0, 16'hBEEF, 1'b1, 1'b1, 24'h000000, 8'd2},  // R2 tagged write
    '{5'd8,  4'd0,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000000, 8'd3},  // R3 test true
    '{5'd0,  4'd2,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000001, 8'd3},  // R3 count 1
    '{5'd1,  4'd0,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h00007A, 8'd6},  // R6 busy fifo
    '{5'd0,  4'd1,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h001234, 8'd1},  // R1 pop untagged
    '{5'd0,  4'd0,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h01BEEF, 8'd1},  // R1 pop tagged
    '{5'd8,  4'd0,  1'b0, 16'h0000, 1'b1, 1'b0, 24'h000000, 8'd3},  // R3 test false
    '{5'd0,  4'd3,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000000, 8'd3},  // R3 count 0
    '{5'd16, 4'd4,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000000, 8'd4},  // R4 good++
    '{5'd16, 4'd4,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000000, 8'd4},  // R4 good++
    '{5'd0,  4'd5,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000002, 8'd4},  // R4 good=2
    '{5'd16, 4'd6,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000000, 8'd4},  // R4 bad++
    '{5'd0,  4'd7,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000001, 8'd4},  // R4 bad=1
    '{5'd16, 4'd7,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000000, 8'd4},  // R4 bad clear
    '{5'd0,  4'd6,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000000, 8'd4},  // R4 bad=0
    '{5'd16, 4'd8,  1'b0, 16'hC35A, 1'b1, 1'b1, 24'h000000, 8'd5},  // R5 address write
    '{5'd0,  4'd8,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h00005A, 8'd5},  // R5 address read
    '{5'd16, 4'd2,  1'b0, 16'h0003, 1'b1, 1'b1, 24'h000000, 8'd3},  // R3 load count
    '{5'd0,  4'd3,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000003, 8'd3},  // R3 count 3
    '{5'd26, 4'd0,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000000, 8'd7},  // R7 enable irq
    '{5'd1,  4'd1,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000003, 8'd7},  // R7 ctrl 3
    '{5'd17, 4'd1,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000000, 8'd7},  // R7 rx off
    '{5'd1,  4'd1,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000002, 8'd7},  // R7 ctrl 2
    '{5'd17, 4'd1,  1'b0, 16'h0001, 1'b1, 1'b1, 24'h000000, 8'd7},  // R7 rx on
    '{5'd24, 4'd0,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000000, 8'd7},  // R7 disable irq
    '{5'd1,  4'd1,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000001, 8'd7},  // R7 ctrl 1
    '{5'd16, 4'd4,  1'b1, 16'h0000, 1'b1, 1'b0, 24'h000000, 8'd10}, // R10 refused inc
    '{5'd0,  4'd4,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000002, 8'd10}, // R10 good still 2
    '{5'd2,  4'd0,  1'b0, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'd11}, // R11 unknown F
    '{5'd16, 4'd9,  1'b0, 16'h0077, 1'b0, 1'b0, 24'h000000, 8'd11}, // R11 unknown A
    '{5'd0,  4'd8,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h00005A, 8'd11}, // R11 address intact
    '{5'd0,  4'd15, 1'b0, 16'h0000, 1'b0, 1'b0, 24'h000000, 8'd11}, // R11 unknown read
    '{5'd0,  4'd2,  1'b1, 16'h0000, 1'b1, 1'b0, 24'h000000, 8'd10}, // R10 refused read
    '{5'd0,  4'd2,  1'b0, 16'h0000, 1'b1, 1'b1, 24'h000003, 8'd10}  // R10 count still 3
  };

  int n_cmp = 0;
  int n_bad = 0;
  logic        c_valid, c_x, c_q;
  logic [23:0] c_rd, c_nrd;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge where the response is valid
  task automatic cmd(input logic [4:0] f, input logic [3:0] a, input logic [15:0] wd,
                     input logic busy);
    cmd_stb   = 1'b1;
    cmd_func  = f;
    cmd_sub   = a;
    cmd_wdata = wd;
    rx_busy   = busy;
    @(posedge clk);
    @(negedge clk);
    cmd_stb = 1'b0;
    rx_busy = 1'b0;
    c_valid = rsp_valid;
    c_x     = rsp_x;
    c_q     = rsp_q;
    c_rd    = rsp_rdata;
    c_nrd   = n_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_stb = 1'b0; cmd_func = '0; cmd_sub = '0; cmd_wdata = '0;
    rx_busy = 1'b0; carrier_det = 1'b1; chan_id = 4'hA;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check("R12 rsp_valid", rsp_valid, 0);
    check("R12 station_addr", station_addr, 0);
    check("R12 rx_enable", rx_enable, 1);
    check("R12 lam_req", lam_req, 0);
    check("R12 rx_init", rx_init, 0);
    cmd(5'd0, 4'd4, 16'h0, 1'b0);
    check("R12 good count", c_rd, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      cmd(VECS[i].f, VECS[i].a, VECS[i].wd, VECS[i].busy);
      check($sformatf("R9 vec%0d valid", i), c_valid, 1);
      check($sformatf("R%0d vec%0d x", VECS[i].rq, i), c_x, VECS[i].ex);
      check($sformatf("R%0d vec%0d q", VECS[i].rq, i), c_q, VECS[i].eq);
      check($sformatf("R%0d vec%0d rdata", VECS[i].rq, i), c_rd, VECS[i].erd);
    end

    // R7 interrupt request follows enable with count 3
    cmd(5'd26, 4'd0, 16'h0, 1'b0);
    check("R7 lam_req on", lam_req, 1);
    cmd(5'd24, 4'd0, 16'h0, 1'b0);
    check("R7 lam_req off", lam_req, 0);

    // R8 module reset through F9
    cmd(5'd26, 4'd0, 16'h0, 1'b0);
    cmd(5'd16, 4'd0, 16'h0055, 1'b0);
    cmd(5'd9, 4'd3, 16'h0, 1'b0);
    check("R8 reset x", c_x, 1);
    check("R8 reset q", c_q, 1);
    check("R8 rx_init pulse", rx_init, 1);
    cmd(5'd0, 4'd4, 16'h0, 1'b0);
    check("R8 good cleared", c_rd, 0);
    check("R8 rx_init single", rx_init, 0);
    check("R8 station cleared", station_addr, 0);
    check("R8 lam_req off", lam_req, 0);
    check("R8 rx_enable set", rx_enable, 1);
    cmd(5'd0, 4'd0, 16'h0, 1'b0);
    check("R8 fifo emptied q", c_q, 0);
    cmd(5'd0, 4'd2, 16'h0, 1'b0);
    check("R8 tag count cleared", c_rd, 0);
    cmd(5'd1, 4'd1, 16'h0, 1'b0);
    check("R8 ctrl readback", c_rd, 1);
    cmd(5'd16, 4'd6, 16'h0, 1'b0);
    cmd(5'd11, 4'd0, 16'h0, 1'b0);
    check("R8 F11 q", c_q, 1);
    cmd(5'd0, 4'd6, 16'h0, 1'b0);
    check("R8 F11 bad cleared", c_rd, 0);

    // R10 a refused reset changes nothing
    cmd(5'd16, 4'd8, 16'h0033, 1'b0);
    cmd(5'd9, 4'd0, 16'h0, 1'b1);
    check("R10 reset refused x", c_x, 1);
    check("R10 reset refused q", c_q, 0);
    check("R10 station kept", station_addr, 8'h33);
    check("R10 no init pulse", rx_init, 0);

    // R2 fill to the limit, R6 full status, R3 count 32
    for (int i = 0; i < 64; i++) begin
      cmd(5'd16, {3'b000, i[0]}, 16'((i * 257 + 5) & 16'hFFFF), 1'b0);
      check($sformatf("R2 fill %0d q", i), c_q, 1);
    end
    cmd(5'd16, 4'd1, 16'hDEAD, 1'b0);
    check("R2 write when full q", c_q, 0);
    cmd(5'd1, 4'd0, 16'h0, 1'b0);
    check("R6 full status", c_rd, 24'h00003A);
    cmd(5'd0, 4'd2, 16'h0, 1'b0);
    check("R3 tag count 32", c_rd, 32);
    cmd(5'd8, 4'd0, 16'h0, 1'b0);
    check("R3 test with tags", c_q, 1);
    for (int i = 0; i < 64; i++) begin
      cmd(5'd0, 4'd0, 16'h0, 1'b0);
      check($sformatf("R1 drain %0d q", i), c_q, 1);
      check($sformatf("R1 drain %0d data", i), c_rd,
            {7'd0, i[0], 16'((i * 257 + 5) & 16'hFFFF)});
    end
    cmd(5'd0, 4'd1, 16'h0, 1'b0);
    check("R1 pop after drain q", c_q, 0);
    cmd(5'd0, 4'd2, 16'h0, 1'b0);
    check("R3 tag count back to 0", c_rd, 0);

    // R4 wrap, seen on the 4-bit instance
    for (int i = 0; i < 17; i++) cmd(5'd16, 4'd4, 16'h0, 1'b0);
    cmd(5'd0, 4'd4, 16'h0, 1'b0);
    check("R4 wide count 17", c_rd, 17);
    check("R4 narrow wrapped to 1", c_nrd, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule